// File: doc/BRIEF.md
# JTAG Debug-Bus Access Controller

This block lives in the test-clock domain of a debug transport module. It owns one JTAG data register. The host scans that register to start read and write operations on a debug module bus. On later scans the host collects the status and read data of those operations. The TAP state machine supplies one-cycle strobes for the capture, shift and update states. The request leaves through a valid/ready handshake toward a clock-domain crossing, and the response comes back as a single-cycle valid pulse.

An operation counts as busy from the update that launches it until its response valid arrives, however long the crossing takes. A capture anywhere in that window reports "in progress", and that capture also sets a sticky flag. The flag keeps every later capture reporting "in progress" until the host pulses the clear input, which it does by writing the clear bit of the transport control/status register. A nonzero operation scanned in while the block is busy or the flag is set is discarded, and it also sets the flag. So a host that polls too early can never mistake stale data for a finished result.

Top module: `dbg_access_ctrl`

## Requirements
- R1: After reset no request is pending, the serial output is 0, and the first capture loads an all-zero register.
- R2: The scan register is {addr[6:0], data[31:0], op[1:0]} with op in bits 1:0. An update with op 1 (read) or 2 (write) while idle and not flagged raises the request on the next cycle. The request carries the address, data and op fields.
- R3: An update with op 0 issues no request and leaves the stored result unchanged.
- R4: While the request is valid and ready is low, valid stays high and the address, data and op outputs stay stable.
- R5: The operation is busy from its launching update up to and including the cycle its response valid is sampled. A capture in any such cycle loads status 3 into bits 1:0.
- R6: A capture during busy sets a sticky flag. While the flag is set, every capture loads status 3, even after the response has returned.
- R7: The clear pulse resets the sticky flag but does not end an operation in flight. A capture after the clear and before the response still loads status 3, and the operation still completes.
- R8: A capture with nothing in flight and the flag clear loads {last launched address, response data, response status}. The response status is 0 for success or 2 for failure.
- R9: An update with a nonzero op while busy or flagged issues no request, leaves the request outputs unchanged, and sets the sticky flag.
- R10: Each shift cycle moves the register one place toward bit 0. The serial input enters bit 40, and the serial output always shows bit 0.
- R11: A response valid that arrives while nothing is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| capture_i | input | 1 | Capture-DR strobe for this register |
| shift_i | input | 1 | Shift-DR strobe for this register |
| update_i | input | 1 | Update-DR strobe for this register |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (bit 0 of the scan register) |
| sticky_clr_i | input | 1 | One-cycle pulse that clears the sticky busy flag |
| req_valid_o | output | 1 | Bus request valid |
| req_ready_i | input | 1 | Request accepted by the crossing |
| req_addr_o | output | 7 | Request address |
| req_data_o | output | 32 | Request write data |
| req_op_o | output | 2 | Request op (1 read, 2 write) |
| rsp_valid_i | input | 1 | Single-cycle response valid |
| rsp_data_i | input | 32 | Response data |
| rsp_status_i | input | 2 | Response status (0 ok, 2 failed) |

## Verification
The request rises on the cycle after the update edge, so the bench checks its fields at the falling edge that follows that update. The bench counts edges itself. It models the response edge as the accept edge plus the configured latency, which is the launching update plus latency plus one. It then expects status 3 exactly when the capture edge is at or before that response edge. For every latency from 1 to 20 the bench sweeps the capture offset from 0 to the latency, so the last busy capture and the first completed capture are both hit. All captured values are read back serially, with bit k sampled at the falling edge before the k-th shift edge.

// File: rtl/dac_pkg.sv
package dac_pkg;

    localparam int OP_W = 2;
    localparam int ST_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } dac_op_e;

    typedef enum logic [ST_W-1:0] {
        ST_OK   = 2'd0,
        ST_RSVD = 2'd1,
        ST_FAIL = 2'd2,
        ST_BUSY = 2'd3
    } dac_st_e;

    function automatic logic op_starts(dac_op_e op);
        return op != OP_NOP;
    endfunction

endpackage

// File: rtl/dac_scan_reg.sv
module dac_scan_reg #(
    parameter int W = 41
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] q,
    output logic         tdo
);

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (capture) q <= cap_val;
        else if (shift)   q <= {tdi, q[W-1:1]};
    end

    assign tdo = q[0];

endmodule

// File: rtl/dac_tracker.sv
module dac_tracker
    import dac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          update,
    input  dac_op_e       op,
    input  logic          capture,
    input  logic          clear,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    input  dac_st_e       rsp_status,
    output logic          launch,
    output logic          busy,
    output logic [DW-1:0] res_data,
    output dac_st_e       status_out
);

    logic    inflight_q;
    logic    sticky_q;
    logic    wants_op;
    logic    drop_op;
    logic    early_cap;
    logic    rsp_take;
    dac_st_e res_st_q;

    assign wants_op  = update && op_starts(op);
    assign launch    = wants_op && !inflight_q && !sticky_q;
    assign drop_op   = wants_op && (inflight_q || sticky_q);
    assign early_cap = capture && inflight_q;
    assign rsp_take  = rsp_valid && inflight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight_q <= 1'b0;
            sticky_q   <= 1'b0;
            res_data   <= '0;
            res_st_q   <= ST_OK;
        end else begin
            if (launch)        inflight_q <= 1'b1;
            else if (rsp_take) inflight_q <= 1'b0;

            if (drop_op || early_cap) sticky_q <= 1'b1;
            else if (clear)           sticky_q <= 1'b0;

            if (rsp_take) begin
                res_data <= rsp_data;
                res_st_q <= rsp_status;
            end
        end
    end

    assign busy       = inflight_q;
    assign status_out = (sticky_q || inflight_q) ? ST_BUSY : res_st_q;

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        inflight_q && !rsp_valid |=> inflight_q);

    // R6
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        sticky_q && !clear |=> sticky_q);

    // R9
    drop_flag_chk: assert property (@(posedge clk) disable iff (rst)
        update && op != OP_NOP && inflight_q |=> sticky_q && inflight_q);

    // R7
    clear_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
        clear && inflight_q && !rsp_valid |=> busy);

    // R11
    rsp_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !inflight_q && rsp_valid |=> $stable(res_data) && $stable(res_st_q));

endmodule

// File: rtl/dac_req_port.sv
module dac_req_port
    import dac_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  dac_op_e       op_in,
    input  logic          ready,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output dac_op_e       op
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            addr  <= '0;
            data  <= '0;
            op    <= OP_NOP;
        end else if (launch) begin
            valid <= 1'b1;
            addr  <= addr_in;
            data  <= data_in;
            op    <= op_in;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(addr) && $stable(data) && $stable(op));

endmodule

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
    import dac_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic              shift_i,
    input  logic              update_i,
    input  logic              tdi_i,
    output logic              tdo_o,
    input  logic              sticky_clr_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [DATA_W-1:0] req_data_o,
    output logic [OP_W-1:0]   req_op_o,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    input  logic [ST_W-1:0]   rsp_status_i
);

    localparam int SCAN_W  = ADDR_W + DATA_W + OP_W;
    localparam int DATA_LO = OP_W;
    localparam int ADDR_LO = OP_W + DATA_W;

    logic [SCAN_W-1:0] scan_q;
    logic [SCAN_W-1:0] cap_val;
    logic              launch;
    logic              busy;
    logic [DATA_W-1:0] res_data;
    dac_st_e           status_out;
    dac_op_e           scan_op;
    dac_op_e           held_op;

    assign scan_op = dac_op_e'(scan_q[OP_W-1:0]);
    assign cap_val = {req_addr_o, res_data, status_out};
    assign req_op_o = held_op;

    dac_scan_reg #(.W(SCAN_W)) u_scan (
        .clk     (clk),
        .rst     (rst),
        .capture (capture_i),
        .shift   (shift_i),
        .tdi     (tdi_i),
        .cap_val (cap_val),
        .q       (scan_q),
        .tdo     (tdo_o)
    );

    dac_tracker #(.DW(DATA_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .update     (update_i),
        .op         (scan_op),
        .capture    (capture_i),
        .clear      (sticky_clr_i),
        .rsp_valid  (rsp_valid_i),
        .rsp_data   (rsp_data_i),
        .rsp_status (dac_st_e'(rsp_status_i)),
        .launch     (launch),
        .busy       (busy),
        .res_data   (res_data),
        .status_out (status_out)
    );

    dac_req_port #(.AW(ADDR_W), .DW(DATA_W)) u_req (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .addr_in (scan_q[SCAN_W-1:ADDR_LO]),
        .data_in (scan_q[ADDR_LO-1:DATA_LO]),
        .op_in   (scan_op),
        .ready   (req_ready_i),
        .valid   (req_valid_o),
        .addr    (req_addr_o),
        .data    (req_data_o),
        .op      (held_op)
    );

    // R5
    capture_busy_chk: assert property (@(posedge clk) disable iff (rst)
        capture_i && busy |=> scan_q[OP_W-1:0] == ST_BUSY);

    // R2
    req_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid_o) |-> $past(update_i));

    // R2
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> busy);

endmodule

// File: tb/dbg_access_ctrl_test.sv
module dbg_access_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0, tdi_i = 1'b0;
    logic        tdo_o;
    logic        sticky_clr_i = 1'b0;
    logic        req_valid_o;
    logic        req_ready_i = 1'b1;
    logic [6:0]  req_addr_o;
    logic [31:0] req_data_o;
    logic [1:0]  req_op_o;
    logic        rsp_valid_i;
    logic [31:0] rsp_data_i;
    logic [1:0]  rsp_status_i;

    int checks = 0, errors = 0, cyc = 0, lat = 1, n_req = 0;
    logic done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dbg_access_ctrl uut (
        .clk(clk), .rst(rst), .capture_i(capture_i), .shift_i(shift_i),
        .update_i(update_i), .tdi_i(tdi_i), .tdo_o(tdo_o), .sticky_clr_i(sticky_clr_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
        .req_data_o(req_data_o), .req_op_o(req_op_o), .rsp_valid_i(rsp_valid_i),
        .rsp_data_i(rsp_data_i), .rsp_status_i(rsp_status_i)
    );

    function automatic logic [31:0] rsp_word(logic [6:0] a, logic [1:0] op, logic [31:0] d);
        return (op == 2'd1) ? (32'hC0DE0000 ^ (32'(a) * 32'd97)) : (d ^ 32'h5A5A0000);
    endfunction

    function automatic logic [1:0] rsp_code(logic [6:0] a);
        return (a[6:4] == 3'b111) ? 2'd2 : 2'd0;
    endfunction

    // responder: accept edge + lat = response edge
    logic        pend = 1'b0, auto_v = 1'b0, junk_v = 1'b0;
    int          due_e = 0;
    logic [6:0]  p_a = '0;
    logic [31:0] p_d = '0;
    logic [1:0]  p_op = '0;

    always @(posedge clk) begin
        if (pend && cyc + 1 == due_e) pend = 1'b0;
        if (req_valid_o && req_ready_i) begin
            pend = 1'b1; due_e = cyc + 1 + lat;
            p_a = req_addr_o; p_d = req_data_o; p_op = req_op_o;
            n_req++;
        end
    end
    always @(negedge clk) auto_v = pend && (cyc + 1 == due_e);

    assign rsp_valid_i  = auto_v | junk_v;
    assign rsp_data_i   = junk_v ? 32'hDEADBEEF : rsp_word(p_a, p_op, p_d);
    assign rsp_status_i = junk_v ? 2'd2 : rsp_code(p_a);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scan(input logic [40:0] din, input logic upd,
                        output logic [40:0] dout, output int cap_e, output int upd_e);
        @(negedge clk); capture_i = 1'b1; cap_e = cyc + 1;
        @(negedge clk); capture_i = 1'b0;
        for (int i = 0; i < 41; i++) begin
            dout[i] = tdo_o; tdi_i = din[i]; shift_i = 1'b1;
            @(negedge clk);
        end
        shift_i = 1'b0; update_i = upd; upd_e = cyc + 1;
        @(negedge clk); update_i = 1'b0;
    endtask

    task automatic shift_only(input logic [40:0] din, output logic [40:0] dout);
        for (int i = 0; i < 41; i++) begin
            @(negedge clk); dout[i] = tdo_o; tdi_i = din[i]; shift_i = 1'b1;
        end
        @(negedge clk); shift_i = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk); sticky_clr_i = 1'b1;
        @(negedge clk); sticky_clr_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [40:0] dout, dmy;
        logic [6:0]  a;
        logic [31:0] d;
        logic [1:0]  op;
        int ce, ue, ul, due, n0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 req_valid", req_valid_o, 0);
        chk("R1 tdo", tdo_o, 0);
        scan('0, 1'b1, dout, ce, ue);
        chk("R1 capture", dout, 0);

        // R10: shift a pattern in, then shift it back out
        shift_only(41'h1_2345_6789_AB, dmy);
        shift_only(41'h0_F0F0_0F0F_55, dout);
        chk("R10 shift path", dout, 41'h1_2345_6789_AB);

        // R3: op 0 issues nothing and keeps result
        n0 = n_req;
        scan({7'h33, 32'h1234_5678, 2'd0}, 1'b1, dmy, ce, ue);
        repeat (30) @(negedge clk);
        chk("R3 no request", n_req, n0);
        scan('0, 1'b1, dout, ce, ue);
        chk("R3 result kept", dout, 0);

        // Sweep latency and capture offset: R2, R5, R8
        for (int L = 1; L <= 20; L++) begin
            for (int k = 0; k <= L; k++) begin
                lat = L;
                a  = 7'(L * 5 + k);
                op = (k % 2 == 1) ? 2'd2 : 2'd1;
                d  = 32'(L * 1000 + k);
                scan({a, d, op}, 1'b1, dmy, ce, ul);
                chk("R2 valid", req_valid_o, 1);
                chk("R2 fields", {req_addr_o, req_data_o, req_op_o}, {a, d, op});
                repeat (k) @(negedge clk);
                scan('0, 1'b1, dout, ce, ue);
                due = ul + 1 + L;
                if (ce <= due) begin
                    chk("R5 early capture busy", dout[1:0], 2'd3);
                    pulse_clear();
                    repeat (L + 2) @(negedge clk);
                    scan('0, 1'b1, dout, ce, ue);
                end
                chk("R8 completed capture", dout, {a, rsp_word(a, op, d), rsp_code(a)});
            end
        end

        // R6: sticky survives completion until cleared
        lat = 20; a = 7'h15; d = 32'hABCD_0001; op = 2'd1;
        scan({a, d, op}, 1'b1, dmy, ce, ue);
        scan('0, 1'b1, dout, ce, ue);
        chk("R6 early busy", dout[1:0], 2'd3);
        repeat (30) @(negedge clk);
        scan('0, 1'b1, dout, ce, ue);
        chk("R6 sticky after response", dout[1:0], 2'd3);
        pulse_clear();
        scan('0, 1'b1, dout, ce, ue);
        chk("R6 after clear", dout, {a, rsp_word(a, op, d), rsp_code(a)});

        // R7: clear does not end an operation in flight
        lat = 20; a = 7'h71; d = 32'h0000_BEEF; op = 2'd2;
        n0 = n_req;
        scan({a, d, op}, 1'b1, dmy, ce, ue);
        @(negedge clk); capture_i = 1'b1;
        @(negedge clk); capture_i = 1'b0; sticky_clr_i = 1'b1;
        @(negedge clk); sticky_clr_i = 1'b0;
        scan('0, 1'b1, dout, ce, ue);
        chk("R7 busy after clear", dout[1:0], 2'd3);
        pulse_clear();
        repeat (25) @(negedge clk);
        scan('0, 1'b1, dout, ce, ue);
        chk("R7 completes", dout, {a, rsp_word(a, op, d), rsp_code(a)});
        chk("R7 one request", n_req, n0 + 1);

        // R4 and R9: stalled request, second op dropped
        lat = 4; req_ready_i = 1'b0;
        a = 7'h2A; d = 32'h600D_F00D; op = 2'd2;
        n0 = n_req;
        scan({a, d, op}, 1'b1, dmy, ce, ue);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R4 held", {req_valid_o, req_addr_o, req_data_o, req_op_o}, {1'b1, a, d, op});
        end
        scan({7'h05, 32'h1111_2222, 2'd1}, 1'b1, dmy, ce, ue);
        chk("R9 outputs unchanged", {req_valid_o, req_addr_o, req_data_o, req_op_o}, {1'b1, a, d, op});
        @(negedge clk); req_ready_i = 1'b1;
        repeat (12) @(negedge clk);
        chk("R9 single request", n_req, n0 + 1);
        scan('0, 1'b1, dout, ce, ue);
        chk("R9 sticky set", dout[1:0], 2'd3);
        pulse_clear();
        scan('0, 1'b1, dout, ce, ue);
        chk("R9 first op result", dout, {a, rsp_word(a, op, d), rsp_code(a)});

        // R11: stray response while idle
        @(negedge clk); junk_v = 1'b1;
        @(negedge clk); junk_v = 1'b0;
        scan('0, 1'b1, dout, ce, ue);
        chk("R11 stray ignored", dout, {a, rsp_word(a, op, d), rsp_code(a)});

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule